// File: doc/BRIEF.md
# Self-Programming Command Register

This block holds the control and status byte that steers program-memory self-programming. Software writes a command pattern into the byte to arm it. The next store-program instruction then carries out the armed action, provided it comes inside a short window. The action is one of four: filling one word of the temporary page buffer, clearing that buffer, erasing a flash page, or writing a flash page. A read of the lock or fuse bytes is armed the same way and is carried out by the next load-program instruction.

An armed command clears itself when its window runs out unused. A buffer fill, a buffer clear or a lock/fuse read also clears the command on the cycle after it is used. An erase or write holds the CPU halted and keeps its bits visible until the flash timer reports completion on the done input. The flash array and the buffer storage sit outside this block. Only five exact patterns can change the register.

Top module: `pgm_cmd_ctl`

## Requirements
- R1: After reset the register reads 0x00, `cpu_halt`, `buf_we`, `buf_clr`, `fl_erase`, `fl_write` and `ld_sel` are low, and `ld_data` is zero.
- R2: The read value is {3'b000, clear-buffer (bit 4), lock/fuse-read (bit 3), page-write (bit 2), page-erase (bit 1), enable (bit 0)}. Bits 7:5 always read as zero.
- R3: When no erase or write is running, a write changes the register only if `reg_wdata[4:0]` is one of 5'b00001 (fill), 5'b00011 (erase), 5'b00101 (page write), 5'b01001 (lock/fuse read) or 5'b10001 (clear buffer). Bits 7:5 of the written byte are ignored. Any other low-five-bit value leaves the register unchanged.
- R4: An accepted write of fill, erase, page write or clear stays readable for exactly ARM_CYCLES (4) cycles and then reads 0x00 if no store instruction is taken. A lock/fuse read stays readable for LOAD_CYCLES (3) cycles if no load instruction is taken. A command bit is never set while the enable bit is clear.
- R5: A store strobe while fill is armed raises `buf_we` in that same cycle, with `buf_idx` = `zptr[PW:1]` (Z bit 0 ignored) and `buf_wdata` = `r_pair`. The register reads 0x00 from the next cycle.
- R6: A store strobe while clear-buffer is armed raises `buf_clr` for that one cycle, leaves `buf_we` low, and clears the register on the next cycle.
- R7: A store strobe while erase or page write is armed starts the operation. From the next cycle `cpu_halt` is high, `fl_erase` or `fl_write` is held high (never both), and `fl_page` = `zptr[ZW-1:PW+1]` as captured at the strobe. `r_pair` is not used. The register keeps reading 0x03 or 0x05.
- R8: When `fl_done` is high during an operation, the register reads 0x00 and `cpu_halt`, `fl_erase` and `fl_write` are low from the next cycle.
- R9: A load strobe while lock/fuse read is armed raises `ld_sel` in that cycle. `ld_data` is `lock_bits` when `zptr[0]`=0 and `fuse_bits` when `zptr[0]`=1. The register then clears on the next cycle. A store strobe during that window has no effect.
- R10: A store or load strobe while nothing is armed raises no buffer, flash, halt or `ld_sel` output and leaves the register at 0x00.
- R11: Register writes while an erase or write is running are ignored.
- R12: An accepted write while a command is armed replaces that command and restarts its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| st_strobe | input | 1 | Store-program instruction executes this cycle |
| ld_strobe | input | 1 | Load-program instruction executes this cycle |
| zptr | input | ZW | Z pointer |
| r_pair | input | DW | R1:R0 data word |
| lock_bits | input | FW | Lock byte |
| fuse_bits | input | FW | Fuse byte |
| fl_done | input | 1 | Flash timer reports end of erase or write |
| buf_we | output | 1 | Temporary buffer word write |
| buf_idx | output | PW | Word index within the buffer |
| buf_wdata | output | DW | Word written to the buffer |
| buf_clr | output | 1 | Clear the whole temporary buffer |
| fl_erase | output | 1 | Page erase in progress |
| fl_write | output | 1 | Page write in progress |
| fl_page | output | ZW-PW-1 | Page address of the running operation |
| cpu_halt | output | 1 | Halt the CPU |
| ld_sel | output | 1 | Load returns `ld_data` instead of program memory |
| ld_data | output | FW | Lock or fuse byte for the load |

## Verification
The assertions assume that `fl_done` is only raised while an operation is running. They also assume that a register write never coincides with a store or load strobe, because the CPU issues at most one of these per cycle. The stimulus drives every input on the falling edge. It pulses done only during the halt, after several busy cycles. It never combines a write with an instruction strobe, and it places strobes on the first and last cycle of each window and on the cycle just after it.

// File: rtl/pgm_cmd_pkg.sv
package pgm_cmd_pkg;

    localparam int CMD_W   = 5;
    localparam int BIT_EN  = 0;
    localparam int BIT_ERS = 1;
    localparam int BIT_WR  = 2;
    localparam int BIT_RD  = 3;
    localparam int BIT_CLR = 4;

    localparam logic [CMD_W-1:0] PAT_FILL  = 5'b00001;
    localparam logic [CMD_W-1:0] PAT_ERASE = 5'b00011;
    localparam logic [CMD_W-1:0] PAT_WRITE = 5'b00101;
    localparam logic [CMD_W-1:0] PAT_FUSE  = 5'b01001;
    localparam logic [CMD_W-1:0] PAT_CLEAR = 5'b10001;

    typedef enum logic [2:0] {
        MODE_IDLE,
        MODE_FILL,
        MODE_CLEAR,
        MODE_ERASE,
        MODE_WRITE,
        MODE_FUSE
    } mode_e;

    function automatic mode_e pat_to_mode(input logic [CMD_W-1:0] p);
        mode_e m;
        case (p)
            PAT_FILL:  m = MODE_FILL;
            PAT_ERASE: m = MODE_ERASE;
            PAT_WRITE: m = MODE_WRITE;
            PAT_FUSE:  m = MODE_FUSE;
            PAT_CLEAR: m = MODE_CLEAR;
            default:   m = MODE_IDLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pgm_cmd_decode.sv
module pgm_cmd_decode
    import pgm_cmd_pkg::*;
(
    input  logic [CMD_W-1:0] wr_pat,
    input  logic [CMD_W-1:0] held_pat,
    output logic             wr_legal,
    output logic             wr_short,
    output mode_e            held_mode
);

    mode_e wr_mode;

    always_comb begin
        wr_mode   = pat_to_mode(wr_pat);
        wr_legal  = (wr_mode != MODE_IDLE);
        wr_short  = (wr_mode == MODE_FUSE);
        held_mode = pat_to_mode(held_pat);
    end

endmodule

// File: rtl/pgm_arm_timer.sv
module pgm_arm_timer #(
    parameter int ARM_CYCLES  = 4,
    parameter int LOAD_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_short,
    input  logic run,
    output logic expire
);

    localparam int MAXC = (ARM_CYCLES > LOAD_CYCLES) ? ARM_CYCLES : LOAD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_short ? CW'(LOAD_CYCLES) : CW'(ARM_CYCLES);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = run && (cnt_q == CW'(1));

endmodule

// File: rtl/pgm_cmd_ctl.sv
module pgm_cmd_ctl
    import pgm_cmd_pkg::*;
#(
    parameter int ZW          = 16,
    parameter int PW          = 5,
    parameter int DW          = 16,
    parameter int FW          = 8,
    parameter int ARM_CYCLES  = 4,
    parameter int LOAD_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 st_strobe,
    input  logic                 ld_strobe,
    input  logic [ZW-1:0]        zptr,
    input  logic [DW-1:0]        r_pair,
    input  logic [FW-1:0]        lock_bits,
    input  logic [FW-1:0]        fuse_bits,
    input  logic                 fl_done,
    output logic                 buf_we,
    output logic [PW-1:0]        buf_idx,
    output logic [DW-1:0]        buf_wdata,
    output logic                 buf_clr,
    output logic                 fl_erase,
    output logic                 fl_write,
    output logic [ZW-PW-2:0]     fl_page,
    output logic                 cpu_halt,
    output logic                 ld_sel,
    output logic [FW-1:0]        ld_data
);

    localparam int PG_W = ZW - PW - 1;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             busy;
        logic [PG_W-1:0]  page;
    } state_t;

    state_t st_d, st_q;

    logic  wr_legal, wr_short, expire;
    logic  armed, take_st, take_ld, accept, tick;
    mode_e held_mode;
    logic  unused_hi;

    assign unused_hi = ^reg_wdata[7:CMD_W];

    pgm_cmd_decode u_dec (
        .wr_pat    (reg_wdata[CMD_W-1:0]),
        .held_pat  (st_q.cmd),
        .wr_legal  (wr_legal),
        .wr_short  (wr_short),
        .held_mode (held_mode)
    );

    assign armed   = st_q.cmd[BIT_EN] && !st_q.busy;
    assign take_st = armed && st_strobe && (held_mode != MODE_FUSE) && (held_mode != MODE_IDLE);
    assign take_ld = armed && ld_strobe && (held_mode == MODE_FUSE);
    assign accept  = reg_we && wr_legal && !st_q.busy && !take_st && !take_ld;
    assign tick    = armed && !take_st && !take_ld && !accept;

    pgm_arm_timer #(
        .ARM_CYCLES  (ARM_CYCLES),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_short (wr_short),
        .run        (tick),
        .expire     (expire)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (fl_done) begin
                st_d.cmd  = '0;
                st_d.busy = 1'b0;
            end
        end else if (take_st) begin
            if (held_mode == MODE_ERASE || held_mode == MODE_WRITE) begin
                st_d.busy = 1'b1;
                st_d.page = zptr[ZW-1:PW+1];
            end else begin
                st_d.cmd = '0;
            end
        end else if (take_ld) begin
            st_d.cmd = '0;
        end else if (accept) begin
            st_d.cmd = reg_wdata[CMD_W-1:0];
        end else if (expire) begin
            st_d.cmd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = {{(8-CMD_W){1'b0}}, st_q.cmd};
    assign buf_we    = take_st && (held_mode == MODE_FILL);
    assign buf_clr   = take_st && (held_mode == MODE_CLEAR);
    assign buf_idx   = zptr[PW:1];
    assign buf_wdata = r_pair;
    assign fl_erase  = st_q.busy && st_q.cmd[BIT_ERS];
    assign fl_write  = st_q.busy && st_q.cmd[BIT_WR];
    assign fl_page   = st_q.page;
    assign cpu_halt  = st_q.busy;
    assign ld_sel    = take_ld;
    assign ld_data   = take_ld ? (zptr[0] ? fuse_bits : lock_bits) : '0;

endmodule

// File: rtl/pgm_cmd_ctl_chk.sv
module pgm_cmd_ctl_chk
    import pgm_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       st_strobe,
    input logic       buf_we,
    input logic       buf_clr,
    input logic       fl_erase,
    input logic       fl_write,
    input logic       fl_done,
    input logic       cpu_halt,
    input logic       ld_sel
);

    logic wr_ok;
    assign wr_ok = (pat_to_mode(reg_wdata[CMD_W-1:0]) != MODE_IDLE);

    always_comb begin
        if (rst_n) begin
            a_r2_reserved_zero: assert (reg_rdata[7:5] == 3'b000);
        end
    end

    a_r3_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && !wr_ok && reg_rdata == 8'h00 && !cpu_halt |=> reg_rdata == 8'h00);

    a_r4_cmd_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> reg_rdata[4:1] == 4'b0000);

    a_r5_fill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> reg_rdata == 8'h00);

    a_r6_clear_not_fill: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clr |-> !buf_we && reg_rdata[4:0] == 5'b10001);

    a_r7_halt_from_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> $past(st_strobe));

    a_r7_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> $countones({fl_erase, fl_write}) == 1);

    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt && fl_done |=> !cpu_halt && reg_rdata == 8'h00);

    a_r9_load_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        ld_sel |-> reg_rdata[4:0] == 5'b01001);

    a_r10_idle_store: assert property (@(posedge clk) disable iff (!rst_n)
        st_strobe && !reg_rdata[0] |-> !buf_we && !buf_clr);

    a_r11_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt && reg_we && !fl_done |=> $stable(reg_rdata));

endmodule

bind pgm_cmd_ctl pgm_cmd_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .st_strobe (st_strobe),
    .buf_we    (buf_we),
    .buf_clr   (buf_clr),
    .fl_erase  (fl_erase),
    .fl_write  (fl_write),
    .fl_done   (fl_done),
    .cpu_halt  (cpu_halt),
    .ld_sel    (ld_sel)
);

// File: tb/pgm_cmd_ctl_tb.sv
`timescale 1ns/1ps
module pgm_cmd_ctl_tb_top;

    localparam logic [7:0] LOCKV = 8'hA5;
    localparam logic [7:0] FUSEV = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        st_strobe = 1'b0;
    logic        ld_strobe = 1'b0;
    logic [15:0] zptr = '0;
    logic [15:0] r_pair = '0;
    logic        fl_done = 1'b0;
    logic        buf_we, buf_clr, fl_erase, fl_write, cpu_halt, ld_sel;
    logic [4:0]  buf_idx;
    logic [15:0] buf_wdata;
    logic [9:0]  fl_page;
    logic [7:0]  ld_data;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int m_cmd  = 0;
    int m_busy = 0;
    int m_page = 0;
    int m_left = 0;

    always #10 clk = ~clk;

    pgm_cmd_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .st_strobe(st_strobe), .ld_strobe(ld_strobe),
        .zptr(zptr), .r_pair(r_pair), .lock_bits(LOCKV), .fuse_bits(FUSEV),
        .fl_done(fl_done), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_wdata(buf_wdata), .buf_clr(buf_clr), .fl_erase(fl_erase),
        .fl_write(fl_write), .fl_page(fl_page), .cpu_halt(cpu_halt),
        .ld_sel(ld_sel), .ld_data(ld_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag, input bit we, input logic [7:0] wd,
                       input bit st, input bit ld, input logic [15:0] z,
                       input logic [15:0] r, input bit done);
        int armed, e_st, e_ld, legal, lo;
        @(negedge clk);
        reg_we = we; reg_wdata = wd; st_strobe = st; ld_strobe = ld;
        zptr = z; r_pair = r; fl_done = done;
        #5;
        armed = ((m_cmd & 1) != 0) && (m_busy == 0);
        e_st  = armed && st && (m_cmd != 9);
        e_ld  = armed && ld && (m_cmd == 9);
        chk(tag, "rdata", reg_rdata, m_cmd);
        chk(tag, "buf_we", buf_we, e_st && m_cmd == 1);
        chk(tag, "buf_clr", buf_clr, e_st && m_cmd == 17);
        chk(tag, "fl_erase", fl_erase, m_busy && m_cmd == 3);
        chk(tag, "fl_write", fl_write, m_busy && m_cmd == 5);
        chk(tag, "cpu_halt", cpu_halt, m_busy);
        chk(tag, "ld_sel", ld_sel, e_ld);
        chk(tag, "ld_data", ld_data, e_ld ? (z[0] ? FUSEV : LOCKV) : 8'h00);
        if (e_st && m_cmd == 1) begin
            chk(tag, "buf_idx", buf_idx, (z >> 1) & 31);
            chk(tag, "buf_wdata", buf_wdata, r);
        end
        if (m_busy != 0) chk(tag, "fl_page", fl_page, m_page);
        lo    = wd & 31;
        legal = (lo == 1) || (lo == 3) || (lo == 5) || (lo == 9) || (lo == 17);
        if (m_busy != 0) begin
            if (done) begin m_cmd = 0; m_busy = 0; end
        end else if (e_st) begin
            if (m_cmd == 3 || m_cmd == 5) begin m_busy = 1; m_page = z >> 6; end
            else m_cmd = 0;
        end else if (e_ld) begin
            m_cmd = 0;
        end else if (we && legal) begin
            m_cmd  = lo;
            m_left = (lo == 9) ? 3 : 4;
        end else if (armed) begin
            m_left--;
            if (m_left == 0) m_cmd = 0;
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 8'h00, 0, 0, 16'h0000, 16'h0000, 0);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values
        idle("R1", 2);
        // R5: fill two cycles after arming, Z bit0 ignored
        cyc("R5", 1, 8'h01, 0, 0, 0, 0, 0);
        idle("R5", 1);
        cyc("R5", 0, 0, 1, 0, 16'h002B, 16'hBEEF, 0);
        idle("R5", 2);
        // R5 and R4: store on last window cycle is taken
        cyc("R4", 1, 8'h01, 0, 0, 0, 0, 0);
        idle("R4", 3);
        cyc("R4", 0, 0, 1, 0, 16'h0016, 16'h1234, 0);
        // R4: window expires after 4 cycles, late store ignored
        cyc("R4", 1, 8'h01, 0, 0, 0, 0, 0);
        idle("R4", 4);
        cyc("R4", 0, 0, 1, 0, 16'h0004, 16'h5555, 0);
        idle("R4", 1);
        // R6: clear buffer
        cyc("R6", 1, 8'h11, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 1, 0, 16'h0010, 16'hAAAA, 0);
        idle("R6", 1);
        // R7 erase with upper write bits set, R11 write during halt, R8 done
        cyc("R7", 1, 8'hE3, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 1, 0, 16'hABCD, 16'h9999, 0);
        idle("R7", 3);
        cyc("R11", 1, 8'h09, 0, 0, 0, 0, 0);
        cyc("R11", 1, 8'h01, 0, 0, 0, 0, 0);
        idle("R7", 2);
        cyc("R8", 0, 0, 0, 0, 0, 0, 1);
        idle("R8", 2);
        // R7 page write
        cyc("R7", 1, 8'h05, 0, 0, 0, 0, 0);
        idle("R7", 2);
        cyc("R7", 0, 0, 1, 0, 16'h1FC0, 16'h0001, 0);
        idle("R7", 5);
        cyc("R8", 0, 0, 0, 0, 0, 0, 1);
        idle("R8", 1);
        // R3: illegal patterns and R2 layout
        cyc("R3", 1, 8'h07, 0, 0, 0, 0, 0);
        cyc("R3", 1, 8'h1F, 0, 0, 0, 0, 0);
        cyc("R3", 1, 8'h02, 0, 0, 0, 0, 0);
        cyc("R3", 1, 8'h08, 0, 0, 0, 0, 0);
        cyc("R3", 1, 8'h19, 0, 0, 0, 0, 0);
        idle("R3", 1);
        cyc("R2", 1, 8'hF1, 0, 0, 0, 0, 0);
        idle("R2", 5);
        // R9: lock read, fuse read, store ignored in window
        cyc("R9", 1, 8'h09, 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 0, 1, 16'h0000, 0, 0);
        idle("R9", 1);
        cyc("R9", 1, 8'h09, 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 1, 0, 16'h0002, 16'h7777, 0);
        cyc("R9", 0, 0, 0, 1, 16'h0001, 0, 0);
        idle("R9", 1);
        // R4: lock read window of 3 expires, late load ignored
        cyc("R4", 1, 8'h09, 0, 0, 0, 0, 0);
        idle("R4", 3);
        cyc("R4", 0, 0, 0, 1, 16'h0001, 0, 0);
        // R10: strobes with nothing armed
        cyc("R10", 0, 0, 1, 0, 16'h0042, 16'h4242, 0);
        cyc("R10", 0, 0, 0, 1, 16'h0001, 0, 0);
        cyc("R10", 0, 0, 1, 1, 16'h0FFF, 16'hFFFF, 0);
        idle("R10", 1);
        // R12: re-arm replaces command and restarts the window
        cyc("R12", 1, 8'h03, 0, 0, 0, 0, 0);
        idle("R12", 2);
        cyc("R12", 1, 8'h01, 0, 0, 0, 0, 0);
        idle("R12", 3);
        cyc("R12", 0, 0, 1, 0, 16'h003E, 16'hC0DE, 0);
        idle("R12", 2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule